// File: doc/BRIEF.md
# Receiver Output Gate

This block sits on the receive side of a serial video link, between the recovered parallel word and the output pins. It decides, every cycle, whether the 24 data lines, the 3 control lines and the pixel clock line carry live recovered traffic or a fixed idle pattern. It makes that choice from the link-lock indication, an active-low power-down input, a sleep-pattern select flag, a power-up hold flag and a software release write.

Two idle patterns exist. The "quiet" pattern drives every output low. The "clock-alive" pattern drives data and control low and lets the pixel clock line keep following the recovered clock. The unlocked and powered-down conditions use the clock-alive pattern differently. Under power-down the data and control lines are also released to high impedance through a separate output-enable. When the hold flag is set, every output is held low after power-up, even once lock is seen, until software writes the release bit. After that write, later lock loss does not bring the hold back; only a power-down does.

The lock input is asynchronous and passes through a flop synchroniser. The power-down, flag and data inputs act on the outputs combinationally, through the registered lock and release state.

Top module: `rx_out_gate`

## Requirements
- R1: While `rst_n` is low, the lock synchroniser and the release flag are cleared, so with `pwrdn_n`=1 and `sleep_sel`=0 all of `dout`, `cout` and `pclk_out` are 0 and `oe` is 1.
- R2: `lock_raw` is synchronised by two flops. A level sampled at a rising edge reaches the output selection after the following rising edge. Lock falling therefore forces the idle pattern within 2 clocks.
- R3: When powered up, not held and unlocked with `sleep_sel`=0, `dout`, `cout` and `pclk_out` are all 0.
- R4: When powered up, not held and unlocked with `sleep_sel`=1, `dout` and `cout` are 0 and `pclk_out` equals `rx_pclk`. Whenever `pwrdn_n`=1, `oe` is 1.
- R5: While `pwrdn_n`=0 and either `sleep_sel`=0 or `hold_cfg`=1, all outputs are 0 and `oe` is 1, in the same cycle.
- R6: While `pwrdn_n`=0, `sleep_sel`=1 and `hold_cfg`=0, `dout` and `cout` are 0, `pclk_out` equals `rx_pclk` and `oe` is 0.
- R7: A rising edge sampled with `pwrdn_n`=0 clears both the lock synchroniser and the release flag. After power-down ends, live data needs two fresh lock samples, and the hold applies again.
- R8: When `hold_cfg`=0, powered up and locked, `dout`=`rx_data`, `cout`=`rx_ctrl`, `pclk_out`=`rx_pclk`, `oe`=1.
- R9: When `hold_cfg`=1, all outputs stay 0 with `oe`=1 until a rising edge samples `rel_wr`=1 with `rel_bit`=1. From the next cycle the block behaves as in R8 when locked.
- R10: With `hold_cfg`=1, `sleep_sel` has no effect: every idle case drives all outputs 0 with `oe`=1.
- R11: Once released, the release flag stays set across lock loss and across later writes with `rel_bit`=0, until power-down or reset.
- R12: A release write sampled while `pwrdn_n`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Power-down, active low (0 = powered down) |
| lock_raw | input | 1 | Asynchronous link-lock indication |
| sleep_sel | input | 1 | Idle pattern select: 0 quiet, 1 clock-alive |
| hold_cfg | input | 1 | Hold all outputs low after power-up until released |
| rel_wr | input | 1 | Write strobe for the release bit |
| rel_bit | input | 1 | Value written to the release bit |
| rx_data | input | 24 | Recovered pixel data |
| rx_ctrl | input | 3 | Recovered control bits |
| rx_pclk | input | 1 | Recovered pixel clock level |
| dout | output | 24 | Gated pixel data |
| cout | output | 3 | Gated control bits |
| pclk_out | output | 1 | Gated pixel clock |
| oe | output | 1 | Output enable for data and control lines (0 = high impedance) |

## Verification
A lock change sampled at one rising edge shows at the outputs only after the second rising edge, and a release write shows after the first. Power-down, sleep select, hold flag and the recovered data act in the same cycle. The reference model keeps a short history of lock samples and takes the next-to-last one as the effective lock, pushing zeros on any reset or power-down edge. It updates its release flag at the rising edge. The outputs are compared with the model at every falling edge, after the rising edge has settled and before new stimulus is driven, so each result is checked in exactly the cycle it is due.

// File: rtl/rog_pkg.sv
package rog_pkg;

   typedef enum logic [2:0] {
      GM_LIVE     = 3'd0,
      GM_HOLD     = 3'd1,
      GM_PD_QUIET = 3'd2,
      GM_PD_TRI   = 3'd3,
      GM_UL_QUIET = 3'd4,
      GM_UL_CLK   = 3'd5
   } gate_mode_e;

   function automatic logic mode_passes_clk(gate_mode_e m);
      return (m == GM_LIVE) || (m == GM_PD_TRI) || (m == GM_UL_CLK);
   endfunction

endpackage

// File: rtl/rog_lock_sync.sv
module rog_lock_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rog_lock_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   chain_q <= '0;
      else if (clr) chain_q <= '0;
      else          chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rog_release.sv
module rog_release (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic wr,
   input  logic wbit,
   output logic released
);
   logic rel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            rel_q <= 1'b0;
      else if (clr)          rel_q <= 1'b0;
      else if (wr && wbit)   rel_q <= 1'b1;
   end

   assign released = rel_q;
endmodule

// File: rtl/rog_mode.sv
module rog_mode
   import rog_pkg::*;
(
   input  logic       pwr_on,
   input  logic       locked,
   input  logic       released,
   input  logic       sleep_sel,
   input  logic       hold_cfg,
   output gate_mode_e mode
);
   logic alive_sel;
   assign alive_sel = sleep_sel && !hold_cfg;

   always_comb begin
      if (!pwr_on)
         mode = alive_sel ? GM_PD_TRI : GM_PD_QUIET;
      else if (hold_cfg && !released)
         mode = GM_HOLD;
      else if (!locked)
         mode = alive_sel ? GM_UL_CLK : GM_UL_QUIET;
      else
         mode = GM_LIVE;
   end
endmodule

// File: rtl/rog_drive.sv
module rog_drive
   import rog_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int CTRL_W = 3
) (
   input  gate_mode_e        mode,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [CTRL_W-1:0] rx_ctrl,
   input  logic              rx_pclk,
   output logic [DATA_W-1:0] dout,
   output logic [CTRL_W-1:0] cout,
   output logic              pclk_out,
   output logic              oe
);
   logic pass_lane;
   assign pass_lane = (mode == GM_LIVE);

   for (genvar g = 0; g < DATA_W; g++) begin : g_data_lane
      assign dout[g] = rx_data[g] & pass_lane;
   end

   for (genvar g = 0; g < CTRL_W; g++) begin : g_ctrl_lane
      assign cout[g] = rx_ctrl[g] & pass_lane;
   end

   assign pclk_out = rx_pclk & mode_passes_clk(mode);
   assign oe       = (mode != GM_PD_TRI);
endmodule

// File: rtl/rx_out_gate.sv
module rx_out_gate
   import rog_pkg::*;
#(
   parameter int DATA_W      = 24,
   parameter int CTRL_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwrdn_n,
   input  logic              lock_raw,
   input  logic              sleep_sel,
   input  logic              hold_cfg,
   input  logic              rel_wr,
   input  logic              rel_bit,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [CTRL_W-1:0] rx_ctrl,
   input  logic              rx_pclk,
   output logic [DATA_W-1:0] dout,
   output logic [CTRL_W-1:0] cout,
   output logic              pclk_out,
   output logic              oe
);
   if (DATA_W < 1) begin : g_bad_data_w
      $error("rx_out_gate: DATA_W must be positive");
   end
   if (CTRL_W < 1) begin : g_bad_ctrl_w
      $error("rx_out_gate: CTRL_W must be positive");
   end

   logic       pd_clr;
   logic       locked;
   logic       released;
   gate_mode_e mode;

   assign pd_clr = !pwrdn_n;

   rog_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (pd_clr),
      .din  (lock_raw),
      .dout (locked)
   );

   rog_release u_rel (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (pd_clr),
      .wr      (rel_wr),
      .wbit    (rel_bit),
      .released(released)
   );

   rog_mode u_mode (
      .pwr_on   (pwrdn_n),
      .locked   (locked),
      .released (released),
      .sleep_sel(sleep_sel),
      .hold_cfg (hold_cfg),
      .mode     (mode)
   );

   rog_drive #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_drive (
      .mode    (mode),
      .rx_data (rx_data),
      .rx_ctrl (rx_ctrl),
      .rx_pclk (rx_pclk),
      .dout    (dout),
      .cout    (cout),
      .pclk_out(pclk_out),
      .oe      (oe)
   );
endmodule

// File: rtl/rx_out_gate_chk.sv
module rx_out_gate_chk #(
   parameter int DATA_W = 24,
   parameter int CTRL_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwrdn_n,
   input logic              lock_raw,
   input logic              sleep_sel,
   input logic              hold_cfg,
   input logic              released,
   input logic [DATA_W-1:0] dout,
   input logic [CTRL_W-1:0] cout,
   input logic              pclk_out,
   input logic              oe
);
   // R2: a low lock sample two edges back forces data and control low
   p_lock_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(lock_raw, 2) |-> (dout == '0) && (cout == '0));

   // R4: output enable stays asserted whenever powered up
   p_oe_powered_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pwrdn_n |-> oe);

   // R5: power-down with quiet pattern or hold drives everything low
   p_pd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwrdn_n && (!sleep_sel || hold_cfg)) |->
         (dout == '0) && (cout == '0) && !pclk_out && oe);

   // R6: power-down with clock-alive pattern releases the lines
   p_pd_tristate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwrdn_n && sleep_sel && !hold_cfg) |->
         !oe && (dout == '0) && (cout == '0));

   // R7: a power-down edge clears the release flag
   p_pd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pwrdn_n |=> !released);

   // R9: before release the hold keeps every output low
   p_hold_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_cfg && !released) |->
         (dout == '0) && (cout == '0) && !pclk_out && oe);

   // R11: the release flag is sticky while powered up
   p_release_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (released && pwrdn_n) |=> released);
endmodule

bind rx_out_gate rx_out_gate_chk #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pwrdn_n  (pwrdn_n),
   .lock_raw (lock_raw),
   .sleep_sel(sleep_sel),
   .hold_cfg (hold_cfg),
   .released (released),
   .dout     (dout),
   .cout     (cout),
   .pclk_out (pclk_out),
   .oe       (oe)
);

// File: tb/rx_out_gate_tb.sv
`timescale 1ns/1ps
module rx_out_gate_tb;
   localparam int DW = 24;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pwrdn_n = 1'b1;
   logic          lock_raw = 1'b0;
   logic          sleep_sel = 1'b0;
   logic          hold_cfg = 1'b0;
   logic          rel_wr = 1'b0;
   logic          rel_bit = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic [CW-1:0] rx_ctrl = '0;
   logic          rx_pclk = 1'b0;
   logic [DW-1:0] dout;
   logic [CW-1:0] cout;
   logic          pclk_out;
   logic          oe;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   rx_out_gate u_dut (
      .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .lock_raw(lock_raw),
      .sleep_sel(sleep_sel), .hold_cfg(hold_cfg), .rel_wr(rel_wr),
      .rel_bit(rel_bit), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
      .rx_pclk(rx_pclk), .dout(dout), .cout(cout), .pclk_out(pclk_out),
      .oe(oe)
   );

   // Behavioural reference: history of lock samples and a release flag
   bit lock_hist[$];
   bit m_rel = 0;

   initial begin
      lock_hist.push_back(1'b0);
      lock_hist.push_back(1'b0);
   end

   always @(posedge clk) begin
      if (!rst_n || !pwrdn_n) begin
         lock_hist.push_back(1'b0);
         lock_hist.push_back(1'b0);
         m_rel <= 0;
      end else begin
         lock_hist.push_back(lock_raw);
         if (rel_wr && rel_bit) m_rel <= 1;
      end
      while (lock_hist.size() > 4) void'(lock_hist.pop_front());
   end

   task automatic compare();
      bit            eff_lock;
      bit            alive;
      logic [DW-1:0] ed;
      logic [CW-1:0] ec;
      logic          ep;
      logic          eo;
      eff_lock = lock_hist[lock_hist.size()-2];
      alive    = sleep_sel && !hold_cfg;
      ed = '0; ec = '0; ep = 1'b0; eo = 1'b1;
      if (!pwrdn_n) begin
         if (alive) begin ep = rx_pclk; eo = 1'b0; end
      end else if (hold_cfg && !m_rel) begin
         // all low
      end else if (!eff_lock) begin
         if (alive) ep = rx_pclk;
      end else begin
         ed = rx_data; ec = rx_ctrl; ep = rx_pclk;
      end
      n_cmp++;
      if (dout !== ed || cout !== ec || pclk_out !== ep || oe !== eo) begin
         n_bad++;
         $display("FAIL %s t=%0t actual d=%h c=%b p=%b oe=%b expected d=%h c=%b p=%b oe=%b",
                  cur_req, $time, dout, cout, pclk_out, oe, ed, ec, ep, eo);
      end
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare();
         rx_data = DW'($urandom);
         rx_ctrl = CW'($urandom);
         rx_pclk = ~rx_pclk;
         rel_wr  = 1'b0;
      end
   endtask

   task automatic rel_write(bit v);
      rel_wr = 1'b1; rel_bit = v;
      step(1);
   endtask

   initial begin
      // R1: reset state
      cur_req = "R1";
      step(4);
      rst_n = 1'b1;
      // R3: unlocked, quiet pattern
      cur_req = "R3";
      step(5);
      // R4: unlocked, clock-alive pattern
      cur_req = "R4";
      sleep_sel = 1'b1;
      step(5);
      // R2/R8: lock rises, live after two edges
      cur_req = "R2";
      lock_raw = 1'b1;
      step(3);
      cur_req = "R8";
      step(6);
      // R2: lock falls, idle within two clocks
      cur_req = "R2";
      lock_raw = 1'b0;
      step(4);
      lock_raw = 1'b1;
      step(4);
      // R5: power-down, quiet
      cur_req = "R5";
      sleep_sel = 1'b0;
      pwrdn_n = 1'b0;
      step(3);
      // R6: power-down, clock-alive with lines released
      cur_req = "R6";
      sleep_sel = 1'b1;
      step(3);
      // R7: leaving power-down needs fresh lock samples
      cur_req = "R7";
      pwrdn_n = 1'b1;
      step(4);
      // R9/R10: hold after power-down, sleep select ignored
      cur_req = "R10";
      hold_cfg = 1'b1;
      pwrdn_n = 1'b0;
      step(3);
      pwrdn_n = 1'b1;
      cur_req = "R9";
      step(5);
      rel_write(1'b0);
      step(2);
      rel_write(1'b1);
      step(4);
      // R11: release survives lock loss and zero writes
      cur_req = "R11";
      lock_raw = 1'b0;
      step(4);
      lock_raw = 1'b1;
      step(3);
      rel_write(1'b0);
      step(3);
      // R12: release write during power-down ignored
      cur_req = "R12";
      pwrdn_n = 1'b0;
      step(2);
      rel_write(1'b1);
      step(1);
      pwrdn_n = 1'b1;
      step(5);
      // R8: mixed stimulus
      cur_req = "R8";
      for (int k = 0; k < 300; k++) begin
         lock_raw  = ($urandom % 8) != 0;
         pwrdn_n   = ($urandom % 16) != 0;
         sleep_sel = $urandom % 2;
         hold_cfg  = ($urandom % 4) == 0;
         rel_wr    = ($urandom % 8) == 0;
         rel_bit   = $urandom % 2;
         @(negedge clk);
         compare();
         rx_data = DW'($urandom);
         rx_ctrl = CW'($urandom);
         rx_pclk = ~rx_pclk;
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog %s actual running expected finished", cur_req);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule